// File: doc/BRIEF.md
# Record and Replay Trace Buffer

This debug unit keeps a history of an internal processor bus in one single-port synchronous RAM. Each traced step is a snapshot of two bus words. In the record phase, a capture pulse writes both words. In the replay phase the same RAM is read back and the unit moves through the history one entry at a time, forward or backward. The two phases never overlap, so a single shared address and data port is enough. Replayed snapshots come out on a registered output bus with a single valid pulse. No latch or strobe signal is produced, so nothing downstream commits a replayed value by mistake.

Two up/down counters generate the addresses: a record index and a replay index. The controller state decides which of them drives the RAM word address. The entry index is the upper part of the word address and the lowest bit selects the word within the snapshot. When the record index passes the last entry, a selectable policy decides what happens. In overwrite mode it wraps, overwrites the oldest entries and sets a flag. In stop mode it sets a full flag, pulses a trap and ignores captures until a clear. At full size the parameters give 32K entries over a 64K-word RAM. The default here is small.

The controller has these states:
- REC_IDLE: recording, waiting for a capture.
- REC_W0: writing the low word.
- REC_W1: writing the high word and advancing the record index.
- REC_FULL: recording stopped because the buffer is full.
- PLAY_IDLE: replay, waiting for a step.
- PLAY_R0: reading the low word.
- PLAY_R1: reading the high word and latching the low word.
- PLAY_OUT: loading the output register.

The transitions are:
- REC_IDLE to REC_W0 on a capture.
- REC_W0 to REC_W1.
- REC_W1 to REC_FULL when the last entry is filled with overwrite off, otherwise REC_W1 to REC_IDLE.
- REC_IDLE or REC_FULL to PLAY_R0 when replay is selected.
- REC_IDLE or REC_FULL to REC_IDLE on a clear.
- PLAY_IDLE to PLAY_R0 on a step.
- PLAY_R0 to PLAY_R1, then PLAY_R1 to PLAY_OUT, then PLAY_OUT to PLAY_IDLE.
- PLAY_IDLE to REC_FULL when record is selected and the full flag is set, otherwise PLAY_IDLE to REC_IDLE.

Top module: `trace_buffer`

## Requirements
- R1: After reset, all of the following are 0: full, wrapped, trap, replay_valid, replay_data, play_idx and mem_addr.
- R2: A capture pulse accepted in REC_IDLE writes cap_lo at word address {record index, 0} in the next cycle and cap_hi at {record index, 1} in the cycle after. The record index then advances by one, so mem_addr reads 2 × entry count (modulo the RAM size) once the controller is idle again.
- R3: A capture pulse is ignored in three cases: while a write is in progress, in replay mode, and while the full flag is set. No stored word and no index changes.
- R4: Selecting replay from a record idle state loads the replay index with the newest entry, (record index − 1) modulo the depth, and reads that entry out.
- R5: In PLAY_IDLE a step pulse moves the replay index by one entry, up when step_up is 1 and down when it is 0, modulo the depth. Steps in record mode have no effect on play_idx.
- R6: replay_data is {high word, low word} of the selected entry. It is updated three clock edges after the edge that accepts the step or the mode change, and replay_valid is high for exactly the following cycle. At all other times replay_data holds its value.
- R7: With overwrite_en = 1, the record index wraps from the last entry to 0 and wrapped is set when it does so. Later captures overwrite the oldest entries.
- R8: With overwrite_en = 0, the capture that fills the last entry sets full and raises trap for exactly one cycle. full then holds until a clear.
- R9: clear_log, in REC_IDLE or REC_FULL, resets the record index, full and wrapped. It has no effect in replay.
- R10: In record states mem_addr carries the record index and in replay states it carries the replay index, each followed by the word bit. RAM writes occur only in record states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_replay | input | 1 | 0 selects record, 1 selects replay |
| overwrite_en | input | 1 | 1 wraps and overwrites, 0 stops when full |
| clear_log | input | 1 | Clears the record index and flags while recording |
| cap_pulse | input | 1 | Capture one snapshot |
| cap_lo | input | DATA_W | Snapshot low word |
| cap_hi | input | DATA_W | Snapshot high word |
| step | input | 1 | Move the replay index by one entry |
| step_up | input | 1 | Step direction, 1 is up |
| replay_data | output | 2*DATA_W | Replayed snapshot {high, low} |
| replay_valid | output | 1 | One-cycle qualifier of replay_data |
| mem_addr | output | IDX_W+1 | Current RAM word address |
| play_idx | output | IDX_W | Replay index |
| full | output | 1 | Stop-mode full flag |
| wrapped | output | 1 | History has wrapped in overwrite mode |
| trap | output | 1 | One-cycle full event |

## Verification
The assertions check the following on every cycle:
- any RAM write goes to the address of the record index;
- no write happens while full is set;
- trap and replay_valid are single-cycle pulses;
- full is never lost without a clear;
- replay_data changes only together with replay_valid.

Only the bench scenarios can show that the right data comes back. This covers the newest-entry load on entering replay, backward and forward stepping with wrap-around, overwrite order after the record index wraps, and the exact cycle of trap and replay_valid.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [2:0] {
        ST_REC_IDLE,
        ST_REC_W0,
        ST_REC_W1,
        ST_REC_FULL,
        ST_PLAY_IDLE,
        ST_PLAY_R0,
        ST_PLAY_R1,
        ST_PLAY_OUT
    } trc_state_e;
endpackage

// File: rtl/trc_spram.sv
module trc_spram #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end
endmodule

// File: rtl/trc_updn.sv
module trc_updn #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    input  logic         up,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (en) begin
            q <= up ? q + W'(1) : q - W'(1);
        end
    end
endmodule

// File: rtl/trc_fsm.sv
module trc_fsm
    import trc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_replay,
    input  logic overwrite_en,
    input  logic clear_log,
    input  logic cap_pulse,
    input  logic step,
    input  logic step_up,
    input  logic rec_at_top,
    output logic hold_load,
    output logic mem_we,
    output logic word_sel,
    output logic addr_play,
    output logic rec_inc,
    output logic rec_clr,
    output logic play_load,
    output logic play_move,
    output logic play_up,
    output logic lo_grab,
    output logic out_load,
    output logic full,
    output logic wrapped,
    output logic trap
);
    trc_state_e state, nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_REC_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state and controls
    always_comb begin
        nxt       = state;
        hold_load = 1'b0;
        mem_we    = 1'b0;
        word_sel  = 1'b0;
        addr_play = 1'b0;
        rec_inc   = 1'b0;
        rec_clr   = 1'b0;
        play_load = 1'b0;
        play_move = 1'b0;
        play_up   = 1'b0;
        lo_grab   = 1'b0;
        out_load  = 1'b0;
        unique case (state)
            ST_REC_IDLE, ST_REC_FULL: begin
                if (clear_log) begin
                    rec_clr = 1'b1;
                    nxt     = ST_REC_IDLE;
                end else if (mode_replay) begin
                    play_load = 1'b1;
                    nxt       = ST_PLAY_R0;
                end else if (cap_pulse && state == ST_REC_IDLE) begin
                    hold_load = 1'b1;
                    nxt       = ST_REC_W0;
                end
            end
            ST_REC_W0: begin
                mem_we = 1'b1;
                nxt    = ST_REC_W1;
            end
            ST_REC_W1: begin
                mem_we   = 1'b1;
                word_sel = 1'b1;
                rec_inc  = 1'b1;
                nxt      = (rec_at_top && !overwrite_en) ? ST_REC_FULL : ST_REC_IDLE;
            end
            ST_PLAY_IDLE: begin
                addr_play = 1'b1;
                if (!mode_replay) begin
                    nxt = full ? ST_REC_FULL : ST_REC_IDLE;
                end else if (step) begin
                    play_move = 1'b1;
                    play_up   = step_up;
                    nxt       = ST_PLAY_R0;
                end
            end
            ST_PLAY_R0: begin
                addr_play = 1'b1;
                nxt       = ST_PLAY_R1;
            end
            ST_PLAY_R1: begin
                addr_play = 1'b1;
                word_sel  = 1'b1;
                lo_grab   = 1'b1;
                nxt       = ST_PLAY_OUT;
            end
            ST_PLAY_OUT: begin
                addr_play = 1'b1;
                out_load  = 1'b1;
                nxt       = ST_PLAY_IDLE;
            end
            default: nxt = ST_REC_IDLE;
        endcase
    end

    // overflow policy flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= 1'b0;
            wrapped <= 1'b0;
            trap    <= 1'b0;
        end else begin
            trap <= 1'b0;
            if (rec_clr) begin
                full    <= 1'b0;
                wrapped <= 1'b0;
            end else if (rec_inc && rec_at_top) begin
                if (overwrite_en) begin
                    wrapped <= 1'b1;
                end else begin
                    full <= 1'b1;
                    trap <= 1'b1;
                end
            end
        end
    end

    // R8
    trap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |=> !trap);
    // R8
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !clear_log) |=> full);
    // R3
    full_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !mem_we);
endmodule

// File: rtl/trace_buffer.sv
module trace_buffer #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mode_replay,
    input  logic                  overwrite_en,
    input  logic                  clear_log,
    input  logic                  cap_pulse,
    input  logic [DATA_W-1:0]     cap_lo,
    input  logic [DATA_W-1:0]     cap_hi,
    input  logic                  step,
    input  logic                  step_up,
    output logic [2*DATA_W-1:0]   replay_data,
    output logic                  replay_valid,
    output logic [IDX_W:0]        mem_addr,
    output logic [IDX_W-1:0]      play_idx,
    output logic                  full,
    output logic                  wrapped,
    output logic                  trap
);
    localparam int ADDR_W = IDX_W + 1;

    logic hold_load, mem_we, word_sel, addr_play, rec_inc, rec_clr;
    logic play_load, play_move, play_up, lo_grab, out_load;
    logic [IDX_W-1:0]  rec_idx;
    logic [DATA_W-1:0] hold_lo, hold_hi, lo_q, ram_q, wdata;

    trc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_replay (mode_replay),
        .overwrite_en(overwrite_en),
        .clear_log   (clear_log),
        .cap_pulse   (cap_pulse),
        .step        (step),
        .step_up     (step_up),
        .rec_at_top  (rec_idx == '1),
        .hold_load   (hold_load),
        .mem_we      (mem_we),
        .word_sel    (word_sel),
        .addr_play   (addr_play),
        .rec_inc     (rec_inc),
        .rec_clr     (rec_clr),
        .play_load   (play_load),
        .play_move   (play_move),
        .play_up     (play_up),
        .lo_grab     (lo_grab),
        .out_load    (out_load),
        .full        (full),
        .wrapped     (wrapped),
        .trap        (trap)
    );

    trc_updn #(.W(IDX_W)) u_rec_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rec_clr),
        .load    (1'b0),
        .load_val('0),
        .en      (rec_inc),
        .up      (1'b1),
        .q       (rec_idx)
    );

    trc_updn #(.W(IDX_W)) u_play_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (1'b0),
        .load    (play_load),
        .load_val(rec_idx - IDX_W'(1)),
        .en      (play_move),
        .up      (play_up),
        .q       (play_idx)
    );

    // address multiplexer: entry index from the active counter, word bit below
    assign mem_addr = {(addr_play ? play_idx : rec_idx), word_sel};
    assign wdata    = word_sel ? hold_hi : hold_lo;

    trc_spram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk  (clk),
        .we   (mem_we),
        .addr (mem_addr),
        .wdata(wdata),
        .rdata(ram_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_lo      <= '0;
            hold_hi      <= '0;
            lo_q         <= '0;
            replay_data  <= '0;
            replay_valid <= 1'b0;
        end else begin
            if (hold_load) begin
                hold_lo <= cap_lo;
                hold_hi <= cap_hi;
            end
            if (lo_grab) begin
                lo_q <= ram_q;
            end
            if (out_load) begin
                replay_data <= {ram_q, lo_q};
            end
            replay_valid <= out_load;
        end
    end

    // R10
    addr_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[ADDR_W-1:1] == rec_idx));
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replay_valid |=> !replay_valid);
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !replay_valid |-> $stable(replay_data));
endmodule

// File: tb/trace_buffer_tb_top.sv
module trace_buffer_tb_top;
    localparam int CLK_P  = 10;
    localparam int DW     = 8;
    localparam int IW     = 3;
    localparam int DEPTH  = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_replay = 1'b0, overwrite_en = 1'b1, clear_log = 1'b0;
    logic cap_pulse = 1'b0, step = 1'b0, step_up = 1'b0;
    logic [DW-1:0] cap_lo = '0, cap_hi = '0;
    logic [2*DW-1:0] replay_data;
    logic replay_valid, full, wrapped, trap;
    logic [IW:0] mem_addr;
    logic [IW-1:0] play_idx;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_lo [DEPTH];
    logic [DW-1:0] m_hi [DEPTH];
    bit  m_wr [DEPTH];
    int  rec_m = 0;
    int  play_m = 0;
    bit  full_m = 0;
    bit  wrap_m = 0;

    always #(CLK_P/2) clk = ~clk;

    trace_buffer #(.DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_replay(mode_replay),
        .overwrite_en(overwrite_en), .clear_log(clear_log),
        .cap_pulse(cap_pulse), .cap_lo(cap_lo), .cap_hi(cap_hi),
        .step(step), .step_up(step_up),
        .replay_data(replay_data), .replay_valid(replay_valid),
        .mem_addr(mem_addr), .play_idx(play_idx),
        .full(full), .wrapped(wrapped), .trap(trap)
    );

    function automatic logic [DW-1:0] lo_of(input int k, input int b);
        return DW'(k * 7 + b + 1);
    endfunction
    function automatic logic [DW-1:0] hi_of(input int k, input int b);
        return DW'(k * 13 + b + 100);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // capture: E0 accepts, E1 writes low, E2 writes high and advances
    task automatic capture(input int k, input int b, input bit dbl);
        @(negedge clk);
        cap_lo = lo_of(k, b); cap_hi = hi_of(k, b); cap_pulse = 1'b1;
        @(negedge clk);
        if (dbl) begin cap_lo = 8'hEE; cap_hi = 8'hEE; end
        else cap_pulse = 1'b0;
        @(negedge clk);
        cap_pulse = 1'b0;
        @(negedge clk);
        if (!mode_replay && !full_m) begin
            m_lo[rec_m] = lo_of(k, b); m_hi[rec_m] = hi_of(k, b); m_wr[rec_m] = 1;
            if (rec_m == DEPTH - 1) begin
                if (overwrite_en) wrap_m = 1; else full_m = 1;
            end
            rec_m = (rec_m + 1) % DEPTH;
        end
    endtask

    // called one negedge after the accepting edge E0
    task automatic wait_read();
        @(negedge clk);
        @(negedge clk);
        chk("R6 valid low before E3", 32'(replay_valid), 0);
        @(negedge clk);
        chk("R6 valid pulse", 32'(replay_valid), 1);
        chk("R5 play_idx", 32'(play_idx), 32'(play_m));
        chk("R10 replay address", 32'(mem_addr), 32'(play_m * 2));
        if (m_wr[play_m])
            chk("R6 replay data", 32'(replay_data), {16'h0, m_hi[play_m], m_lo[play_m]});
        @(negedge clk);
        chk("R6 valid falls", 32'(replay_valid), 0);
    endtask

    task automatic enter_replay();
        @(negedge clk);
        mode_replay = 1'b1;
        play_m = (rec_m + DEPTH - 1) % DEPTH;
        @(negedge clk);
        wait_read();
    endtask

    task automatic step_play(input bit up);
        @(negedge clk);
        step = 1'b1; step_up = up;
        @(negedge clk);
        step = 1'b0;
        play_m = up ? (play_m + 1) % DEPTH : (play_m + DEPTH - 1) % DEPTH;
        wait_read();
    endtask

    task automatic leave_replay();
        @(negedge clk);
        mode_replay = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 record address", 32'(mem_addr), 32'(rec_m * 2));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_wr[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 full", 32'(full), 0);
        chk("R1 wrapped", 32'(wrapped), 0);
        chk("R1 trap", 32'(trap), 0);
        chk("R1 valid", 32'(replay_valid), 0);
        chk("R1 data", 32'(replay_data), 0);
        chk("R1 play_idx", 32'(play_idx), 0);
        chk("R1 mem_addr", 32'(mem_addr), 0);

        // overwrite mode, five entries, one with a held pulse (R3 ignore while writing)
        overwrite_en = 1'b1;
        for (int k = 0; k < 5; k++) begin
            capture(k, 0, k == 2);
            chk("R2 record advance", 32'(mem_addr), 32'(rec_m * 2));
            chk("R7 not yet wrapped", 32'(wrapped), 0);
        end
        // R5 step ignored in record
        @(negedge clk); step = 1'b1; step_up = 1'b1;
        @(negedge clk); step = 1'b0;
        @(negedge clk);
        chk("R5 step ignored in record", 32'(play_idx), 0);

        // R4 newest entry on entry, then step down past zero
        enter_replay();
        for (int i = 0; i < 5; i++) step_play(1'b0);
        step_play(1'b1);
        // R3 capture in replay ignored
        capture(50, 0, 0);
        for (int i = 0; i < 4; i++) step_play(1'b1);
        leave_replay();

        // R7 wrap and overwrite
        for (int k = 5; k < 11; k++) begin
            capture(k, 0, 0);
            chk("R7 wrapped flag", 32'(wrapped), 32'(wrap_m));
        end
        enter_replay();
        for (int i = 0; i < DEPTH; i++) step_play(1'b0);
        // R9 clear ignored in replay
        @(negedge clk); clear_log = 1'b1;
        @(negedge clk); clear_log = 1'b0;
        @(negedge clk);
        chk("R9 clear ignored in replay", 32'(wrapped), 1);
        leave_replay();

        // R9 clear
        @(negedge clk); clear_log = 1'b1;
        @(negedge clk); clear_log = 1'b0;
        rec_m = 0; wrap_m = 0; full_m = 0;
        @(negedge clk);
        chk("R9 clear index", 32'(mem_addr), 0);
        chk("R9 clear wrapped", 32'(wrapped), 0);
        chk("R9 clear full", 32'(full), 0);

        // R8 stop mode
        overwrite_en = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            capture(k, 40, 0);
            chk("R8 trap timing", 32'(trap), 32'(k == DEPTH - 1));
            chk("R8 full flag", 32'(full), 32'(k == DEPTH - 1));
        end
        @(negedge clk);
        chk("R8 trap one cycle", 32'(trap), 0);
        // R3 capture while full ignored
        capture(90, 40, 0);
        chk("R3 full ignores capture", 32'(mem_addr), 0);
        chk("R8 full holds", 32'(full), 1);
        chk("R3 no trap again", 32'(trap), 0);
        enter_replay();
        step_play(1'b1);
        leave_replay();
        chk("R8 full kept after replay", 32'(full), 1);
        @(negedge clk); clear_log = 1'b1;
        @(negedge clk); clear_log = 1'b0;
        @(negedge clk);
        chk("R9 clear releases full", 32'(full), 0);

        summary();
        $finish;
    end
endmodule